// File: doc/BRIEF.md
# Grouped-Key Hit Store Writer

This block takes in a stream of hits. Each hit comes with a key, and all hits that share a key arrive one after another. Every hit is written into a hit-list memory at the next free address, so the list stays in arrival order. Two side memories describe where each key's group begins and how long it is. Each side memory is split into eight banks. The low three key bits pick the bank and the remaining upper key bits pick the row. One side memory holds the hit-list address of the first hit of each key (the base pointer). The other holds the number of hits seen so far for that key (the count).

The side memories are never wiped between events. A per-event bitmap holds one bit per row. The first time an event touches a row, the whole row is zeroed in all eight banks, in the same cycle as the new entry is written. Rows that the current event has not touched read back as zero on the inspection port, which returns all eight banks of one row at once. A second read port returns any hit-list entry. These ports let the stored groups be checked and looked up.

Top module: `grouped_hit_store`

## Requirements
- R1: The key is UK_W+3 bits wide (14 bits when UK_W is 11). Key bits [2:0] select one of eight banks. The bits above them form the row address.
- R2: Each hit with inValid high is written into the hit-list memory. Within an event the addresses run 0, 1, 2, … in arrival order. hitRdData returns the entry at hitRdAddr combinationally.
- R3: When a beat's full key differs from the previous beat's key, the selected bank's row gets a count of 1. Its base pointer becomes the hit-list address that beat is written to.
- R4: When a beat's full key equals the previous beat's key, the selected bank's count rises by one. Its base pointer keeps its earlier value.
- R5: When a beat's row has not yet been touched in the current event, the other seven banks of that row read count 0 and base 0 afterwards.
- R6: When a beat's row was already touched in the current event, the other seven banks of that row keep their values.
- R7: rdCount carries bank b's count in bits [b*CNT_W +: CNT_W], and rdBase carries its base in bits [b*PTR_W +: PTR_W]. CNT_W is PTR_W+1 and PTR_W is clog2(HL_DEPTH). Both outputs are combinational from rdAddr. A row not touched in the current event reads zero in every bank.
- R8: A one-cycle evtStart pulse does three things: every row reads as untouched, the next hit goes to address 0, and the previous key is forgotten. A key equal to the last key before the pulse is therefore treated as new.
- R9: A beat that arrives in the same cycle as evtStart is the first beat of the new event.
- R10: Cycles with inValid low change no stored value. They also do not break a run of equal keys.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| evtStart | input | 1 | Event-start pulse |
| inValid | input | 1 | Input beat present |
| inHit | input | HIT_W | Hit word |
| inKey | input | UK_W+3 | Key of the hit |
| rdAddr | input | UK_W | Inspection row address |
| rdCount | output | 8*CNT_W | Counts of the eight banks at rdAddr |
| rdBase | output | 8*PTR_W | Base pointers of the eight banks at rdAddr |
| hitRdAddr | input | PTR_W | Hit-list read address |
| hitRdData | output | HIT_W | Hit-list entry at hitRdAddr |

## Verification
The hardest state to reach from the ports is a row that holds stale data from an earlier event, where the new event then touches a different bank of that row. Only that case shows whether the lazy row clear happened, because the untouched row already reads zero through the bitmap mask. The stimulus fills several banks of one row in a first event. A second event then writes a single other bank of that row, and the old banks are read back. The bench also sends a key equal to the last key of the previous event in the same cycle as the event-start pulse. This checks that the pulse both forgets the previous key and claims that beat for the new event.

// File: rtl/hsw_pkg.sv
package hsw_pkg;
  typedef struct packed {
    logic hitWe;   // write the hit-list entry
    logic cntWe;   // write selected count bank
    logic baseWe;  // write selected base bank
    logic rowClr;  // zero the non-selected banks of the row
    logic mapSet;  // mark the row as touched
    logic mapClr;  // clear the whole bitmap
  } hswStrobe_t;
endpackage

// File: rtl/hsw_ctrl.sv
module hsw_ctrl
  import hsw_pkg::*;
#(
  parameter int KEY_W = 7,
  parameter int PTR_W = 6,
  parameter int CNT_W = PTR_W + 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             evtStart,
  input  logic             inValid,
  input  logic [KEY_W-1:0] inKey,
  input  logic             rowSeen,
  output hswStrobe_t       strb,
  output logic [PTR_W-1:0] wrPtr,
  output logic [CNT_W-1:0] cntVal
);
  logic [KEY_W-1:0] prevKey;
  logic             prevValid;
  logic [PTR_W-1:0] nextAddr;
  logic [CNT_W-1:0] runCnt;
  logic             sameKey;
  logic             newKey;
  logic             seenEff;

  always_comb begin
    sameKey = inValid && prevValid && !evtStart && (inKey == prevKey);
    newKey  = inValid && !sameKey;
    seenEff = rowSeen && !evtStart;
    wrPtr   = evtStart ? '0 : nextAddr;
    cntVal  = sameKey ? runCnt + CNT_W'(1) : CNT_W'(1);
    strb.hitWe  = inValid;
    strb.cntWe  = inValid;
    strb.baseWe = newKey;
    strb.rowClr = newKey && !seenEff;
    strb.mapSet = newKey;
    strb.mapClr = evtStart;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevKey   <= '0;
      prevValid <= 1'b0;
      nextAddr  <= '0;
      runCnt    <= '0;
    end else begin
      if (evtStart) begin
        prevValid <= 1'b0;
        nextAddr  <= '0;
      end
      if (inValid) begin
        prevKey   <= inKey;
        prevValid <= 1'b1;
        nextAddr  <= wrPtr + PTR_W'(1);
        runCnt    <= cntVal;
      end
    end
  end
endmodule

// File: rtl/hsw_dp.sv
module hsw_dp
  import hsw_pkg::*;
#(
  parameter int UK_W     = 4,
  parameter int HIT_W    = 32,
  parameter int HL_DEPTH = 64,
  parameter int PTR_W    = $clog2(HL_DEPTH),
  parameter int CNT_W    = PTR_W + 1
) (
  input  logic               clk,
  input  logic               rstN,
  input  hswStrobe_t         strb,
  input  logic [UK_W+2:0]    inKey,
  input  logic [HIT_W-1:0]   inHit,
  input  logic [PTR_W-1:0]   wrPtr,
  input  logic [CNT_W-1:0]   cntVal,
  output logic               rowSeen,
  input  logic [UK_W-1:0]    rdAddr,
  output logic [8*CNT_W-1:0] rdCount,
  output logic [8*PTR_W-1:0] rdBase,
  input  logic [PTR_W-1:0]   hitRdAddr,
  output logic [HIT_W-1:0]   hitRdData
);
  localparam int ROWS  = 1 << UK_W;
  localparam int BANKS = 8;

  logic [UK_W-1:0]  rowSel;
  logic [2:0]       bankSel;
  logic [ROWS-1:0]  mapBits;
  logic [HIT_W-1:0] hitMem [HL_DEPTH];

  assign rowSel  = inKey[UK_W+2:3];
  assign bankSel = inKey[2:0];
  assign rowSeen = mapBits[rowSel];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mapBits <= '0;
    end else begin
      if (strb.mapClr) mapBits <= '0;
      if (strb.mapSet) mapBits[rowSel] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (strb.hitWe) hitMem[wrPtr] <= inHit;
  end
  assign hitRdData = hitMem[hitRdAddr];

  for (genvar b = 0; b < BANKS; b++) begin : gBank
    logic [CNT_W-1:0] cntMem  [ROWS];
    logic [PTR_W-1:0] baseMem [ROWS];
    logic             isSel;
    assign isSel = (bankSel == 3'(b));

    always_ff @(posedge clk) begin
      if (strb.cntWe && isSel)       cntMem[rowSel] <= cntVal;
      else if (strb.rowClr)          cntMem[rowSel] <= '0;
      if (strb.baseWe && isSel)      baseMem[rowSel] <= wrPtr;
      else if (strb.rowClr)          baseMem[rowSel] <= '0;
    end

    assign rdCount[b*CNT_W +: CNT_W] = mapBits[rdAddr] ? cntMem[rdAddr]  : '0;
    assign rdBase[b*PTR_W +: PTR_W]  = mapBits[rdAddr] ? baseMem[rdAddr] : '0;
  end
endmodule

// File: rtl/grouped_hit_store.sv
module grouped_hit_store
  import hsw_pkg::*;
#(
  parameter int UK_W     = 4,
  parameter int HIT_W    = 32,
  parameter int HL_DEPTH = 64
) (
  input  logic                                   clk,
  input  logic                                   rstN,
  input  logic                                   evtStart,
  input  logic                                   inValid,
  input  logic [HIT_W-1:0]                       inHit,
  input  logic [UK_W+2:0]                        inKey,
  input  logic [UK_W-1:0]                        rdAddr,
  output logic [8*($clog2(HL_DEPTH)+1)-1:0]      rdCount,
  output logic [8*$clog2(HL_DEPTH)-1:0]          rdBase,
  input  logic [$clog2(HL_DEPTH)-1:0]            hitRdAddr,
  output logic [HIT_W-1:0]                       hitRdData
);
  localparam int PTR_W = $clog2(HL_DEPTH);
  localparam int CNT_W = PTR_W + 1;
  localparam int KEY_W = UK_W + 3;

  hswStrobe_t       strb;
  logic [PTR_W-1:0] wrPtr;
  logic [CNT_W-1:0] cntVal;
  logic             rowSeen;

  hsw_ctrl #(.KEY_W(KEY_W), .PTR_W(PTR_W), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .evtStart(evtStart), .inValid(inValid),
    .inKey(inKey), .rowSeen(rowSeen), .strb(strb), .wrPtr(wrPtr),
    .cntVal(cntVal)
  );

  hsw_dp #(.UK_W(UK_W), .HIT_W(HIT_W), .HL_DEPTH(HL_DEPTH),
           .PTR_W(PTR_W), .CNT_W(CNT_W)) uDp (
    .clk(clk), .rstN(rstN), .strb(strb), .inKey(inKey), .inHit(inHit),
    .wrPtr(wrPtr), .cntVal(cntVal), .rowSeen(rowSeen), .rdAddr(rdAddr),
    .rdCount(rdCount), .rdBase(rdBase), .hitRdAddr(hitRdAddr),
    .hitRdData(hitRdData)
  );
endmodule

// File: rtl/grouped_hit_store_chk.sv
module grouped_hit_store_chk
  import hsw_pkg::*;
#(
  parameter int PTR_W = 6,
  parameter int CNT_W = 7
) (
  input logic               clk,
  input logic               rstN,
  input logic               evtStart,
  input logic               inValid,
  input hswStrobe_t         strb,
  input logic [PTR_W-1:0]   wrPtr,
  input logic [CNT_W-1:0]   cntVal,
  input logic [8*CNT_W-1:0] rdCount,
  input logic [8*PTR_W-1:0] rdBase
);
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rstN)
    (inValid && !evtStart) |=> (evtStart || wrPtr == $past(wrPtr) + PTR_W'(1))); // R2
  AST_NEW_COUNT_ONE: assert property (@(posedge clk) disable iff (!rstN)
    strb.baseWe |-> (cntVal == CNT_W'(1))); // R3
  AST_SAME_COUNT_GROWS: assert property (@(posedge clk) disable iff (!rstN)
    (strb.cntWe && !strb.baseWe) |-> (cntVal > CNT_W'(1))); // R4
  AST_CLEAR_ONLY_NEW: assert property (@(posedge clk) disable iff (!rstN)
    strb.rowClr |-> (strb.baseWe && strb.mapSet)); // R5
  AST_EVT_EMPTY: assert property (@(posedge clk) disable iff (!rstN)
    (evtStart && !inValid) |=> (rdCount == '0 && rdBase == '0 && wrPtr == '0)); // R8
endmodule

bind grouped_hit_store grouped_hit_store_chk #(.PTR_W(PTR_W), .CNT_W(CNT_W)) uChk (
  .clk(clk), .rstN(rstN), .evtStart(evtStart), .inValid(inValid),
  .strb(strb), .wrPtr(wrPtr), .cntVal(cntVal), .rdCount(rdCount),
  .rdBase(rdBase)
);

// File: tb/tb_grouped_hit_store.sv
`timescale 1ns/1ps
module tb_grouped_hit_store;
  localparam int UK_W = 4;
  localparam int HIT_W = 32;
  localparam int HL_DEPTH = 64;
  localparam int PW = 6;
  localparam int CW = 7;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic evtStart = 1'b0;
  logic inValid = 1'b0;
  logic [HIT_W-1:0] inHit = '0;
  logic [UK_W+2:0] inKey = '0;
  logic [UK_W-1:0] rdAddr = '0;
  logic [8*CW-1:0] rdCount;
  logic [8*PW-1:0] rdBase;
  logic [PW-1:0] hitRdAddr = '0;
  logic [HIT_W-1:0] hitRdData;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  grouped_hit_store #(.UK_W(UK_W), .HIT_W(HIT_W), .HL_DEPTH(HL_DEPTH)) dut (
    .clk(clk), .rstN(rstN), .evtStart(evtStart), .inValid(inValid),
    .inHit(inHit), .inKey(inKey), .rdAddr(rdAddr), .rdCount(rdCount),
    .rdBase(rdBase), .hitRdAddr(hitRdAddr), .hitRdData(hitRdData)
  );

  task automatic chk(input string tag, input longint got, input longint exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, got, exp);
    end
  endtask

  function automatic logic [UK_W+2:0] mkKey(input int row, input int bank);
    return {UK_W'(row), 3'(bank)};
  endfunction

  task automatic beat(input int row, input int bank, input logic [HIT_W-1:0] h,
                      input logic withEvt);
    @(negedge clk);
    inKey = mkKey(row, bank); inHit = h; inValid = 1'b1; evtStart = withEvt;
    @(negedge clk);
    inValid = 1'b0; evtStart = 1'b0;
  endtask

  task automatic pulseEvt();
    @(negedge clk); evtStart = 1'b1;
    @(negedge clk); evtStart = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic chkBank(input string tag, input int row, input int bank,
                         input int expCnt, input int expBase);
    rdAddr = UK_W'(row); #1;
    chk({tag, " count"}, longint'(rdCount[bank*CW +: CW]), expCnt);
    chk({tag, " base"},  longint'(rdBase[bank*PW +: PW]), expBase);
  endtask

  task automatic chkRowZero(input string tag, input int row, input int skipA,
                            input int skipB);
    rdAddr = UK_W'(row); #1;
    for (int b = 0; b < 8; b++) begin
      if (b != skipA && b != skipB) begin
        chk({tag, " count"}, longint'(rdCount[b*CW +: CW]), 0);
        chk({tag, " base"},  longint'(rdBase[b*PW +: PW]), 0);
      end
    end
  endtask

  task automatic chkHit(input string tag, input int addr, input logic [HIT_W-1:0] exp);
    hitRdAddr = PW'(addr); #1;
    chk(tag, longint'(hitRdData), longint'(exp));
  endtask

  // Reset: nothing touched, every row reads zero (R7)
  task automatic tReset();
    for (int r = 0; r < 16; r += 5) chkRowZero("R7 reset row zero", r, 9, 9);
  endtask

  // First event: grouped keys, idle gaps inside a group (R1 R2 R3 R4 R10)
  task automatic tFirstEvent();
    pulseEvt();
    beat(2, 5, 32'hA000_0000, 1'b0);
    beat(2, 5, 32'hA000_0001, 1'b0);
    idle(3);
    beat(2, 5, 32'hA000_0002, 1'b0);
    beat(2, 1, 32'hA000_0003, 1'b0);
    beat(7, 0, 32'hA000_0004, 1'b0);
    beat(7, 0, 32'hA000_0005, 1'b0);
    idle(2);
    chkBank("R4 R10 run of three across idle", 2, 5, 3, 0);
    chkBank("R3 R1 new low bits same row", 2, 1, 1, 3);
    chkRowZero("R5 R1 other banks row2", 2, 5, 1);
    chkBank("R4 second key count", 7, 0, 2, 4);
    chkRowZero("R7 untouched row", 3, 9, 9);
    for (int i = 0; i < 6; i++) chkHit("R2 hit order", i, 32'hA000_0000 + i);
  endtask

  // Second event: stale rows cleared lazily, touched rows kept (R5 R6 R8)
  task automatic tSecondEvent();
    pulseEvt();
    chkRowZero("R8 row2 after event start", 2, 9, 9);
    chkRowZero("R8 row7 after event start", 7, 9, 9);
    beat(2, 1, 32'hB000_0000, 1'b0);
    beat(7, 3, 32'hB000_0001, 1'b0);
    chkBank("R8 R3 address restarts", 2, 1, 1, 0);
    chkRowZero("R5 stale bank5 cleared", 2, 1, 1);
    chkBank("R3 row7 bank3", 7, 3, 1, 1);
    chkRowZero("R5 stale bank0 cleared", 7, 3, 3);
    beat(2, 5, 32'hB000_0002, 1'b0);
    beat(2, 5, 32'hB000_0003, 1'b0);
    chkBank("R4 R6 revisited row new bank", 2, 5, 2, 2);
    chkBank("R6 earlier bank kept", 2, 1, 1, 0);
    chkBank("R6 row7 untouched by row2", 7, 3, 1, 1);
    chkHit("R2 hit overwrite at 0", 0, 32'hB000_0000);
    chkHit("R2 hit at 3", 3, 32'hB000_0003);
  endtask

  // Beat with event start, same key as last one (R8 R9)
  task automatic tEvtWithBeat();
    beat(2, 5, 32'hC000_0000, 1'b1);
    chkBank("R9 R8 beat joins new event", 2, 5, 1, 0);
    chkRowZero("R9 row2 others cleared", 2, 5, 5);
    chkRowZero("R9 row7 untouched", 7, 9, 9);
    beat(2, 5, 32'hC000_0001, 1'b0);
    chkBank("R4 continues after event beat", 2, 5, 2, 0);
    chkHit("R9 hit at 0", 0, 32'hC000_0000);
    chkHit("R2 R9 hit at 1", 1, 32'hC000_0001);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset();
    tFirstEvent();
    tSecondEvent();
    tEvtWithBeat();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule